// File: doc/BRIEF.md
# Decimal Zone/Pack Converter

This block is a streaming engine that turns a character-per-digit (zoned) decimal field into the compact two-digits-per-byte (packed) form, and turns a packed field back into zoned characters. It takes one input byte per accepted handshake. It produces at most one result byte per clock. While it converts, it checks every digit nibble and the sign nibble. A malformed field stops the conversion early and is flagged.

An operation starts with a one-cycle `start` strobe. On that strobe the engine latches three settings: the direction, the character-set mode and the packed byte count. The mode bit picks the zone and sign codes for the result: 0 selects EBCDIC-style codes and 1 selects ASCII-style codes. Input bytes arrive most-significant digit first over a valid/ready pair. Result bytes leave on `out_data` qualified by `out_valid`. There is no back-pressure on the output side. `done` marks the end of every operation and `err` marks an aborted one.

Top module: `dzp_conv`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `done`, `err` and `in_ready` are all low.
- R2: `start` is accepted only when the engine is idle. On acceptance it latches `dir_unpack`, `ascii_mode` and `len_m1`. A `start` pulse during an operation changes neither its settings nor its results.
- R3: Pack (`dir_unpack`=0) with `len_m1`=L reads 2L+1 zoned bytes and writes L+1 packed bytes. The digits are the low nibbles [3:0] of the zoned bytes, placed high nibble first, two per byte. The final packed byte is {last digit, sign}.
- R4: In pack, the sign comes from the zone nibble [7:4] of the last zoned byte. A, C, E and F mean plus; B and D mean minus. The emitted sign is C (plus) or D (minus) in EBCDIC mode, and A (plus) or B (minus) in ASCII mode.
- R5: Unpack (`dir_unpack`=1) turns each packed byte except the last into two zoned bytes, the high digit first. Each of these bytes has zone [7:4] = F in EBCDIC mode or 5 in ASCII mode. `in_ready` is low in the cycle the second byte is produced.
- R6: Unpack turns the last packed byte into one zoned byte {sign zone, high digit}. The sign zone is C or D in EBCDIC mode and A or B in ASCII mode, following the plus/minus meaning of R4 applied to the low nibble.
- R7: Each result byte appears the cycle after the input byte that completes it is accepted. `done` is a one-cycle pulse, and on a good field it is high in the same cycle as the final result byte.
- R8: A digit nibble above 9 in the accepted byte aborts the operation. `done` and `err` pulse together for one cycle, no result byte is produced from that input byte, and the engine returns to idle.
- R9: A sign nibble below A (the last zoned zone in pack, or the last packed low nibble in unpack) aborts the operation exactly as in R8.
- R10: In pack, the zone nibbles of all zoned bytes except the last are ignored.
- R11: The shortest field (`len_m1`=0, one packed byte) and the longest field (`len_m1`=15, sixteen packed bytes and 31 zoned bytes) convert correctly in both directions.
- R12: While the engine is idle, `in_ready` is low and `in_valid` produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (used only when idle) |
| dir_unpack | input | 1 | 0 = zoned to packed, 1 = packed to zoned |
| ascii_mode | input | 1 | 0 = EBCDIC-style codes, 1 = ASCII-style codes |
| len_m1 | input | LEN_W | Packed byte count minus one |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Engine takes the input byte at this edge |
| out_data | output | 8 | Result byte |
| out_valid | output | 1 | Result byte present |
| done | output | 1 | End of operation pulse |
| err | output | 1 | Operation aborted on a bad nibble |

## Verification
Directed fields with known digits and signs pin down nibble placement, and they separate plus codes from minus codes in both character sets and in both directions. Random fields at random lengths, with random zones on the inner bytes and random gaps in `in_valid`, show whether pairing and counting hold for odd and even positions. Single bad nibbles placed at the first, a middle and the sign position show whether the engine stops at the right byte and whether it has already produced the bytes before it. A `start` pulse in the middle of an operation, and `in_valid` driven while idle, show that neither disturbs the engine.

// File: rtl/dzp_pkg.sv
package dzp_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  function automatic logic nib_is_digit(input nib_t n);
    return n <= nib_t'(9);
  endfunction

  function automatic logic nib_is_sign(input nib_t n);
    return n >= nib_t'(10);
  endfunction

  function automatic logic nib_is_minus(input nib_t n);
    return (n == nib_t'(11)) || (n == nib_t'(13));
  endfunction

  // zone placed on ordinary digit characters
  function automatic nib_t zone_plain(input logic ascii);
    return ascii ? nib_t'(5) : nib_t'(15);
  endfunction

  // preferred sign code for the selected character set
  function automatic nib_t sign_pref(input logic ascii, input logic minus);
    if (ascii) return minus ? nib_t'(11) : nib_t'(10);
    else       return minus ? nib_t'(13) : nib_t'(12);
  endfunction

endpackage

// File: rtl/dzp_seq.sv
module dzp_seq
  import dzp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_unpack,
  input  logic             ascii_mode,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             accept,
  input  logic             abort,
  output logic             busy,
  output logic             unpack_q,
  output logic             ascii_q,
  output logic [LEN_W:0]   idx,
  output logic             last,
  output logic             half,
  output logic             in_ready
);

  logic [LEN_W-1:0] len_q;

  // last input index: L for packed input, 2L for zoned input
  assign last     = unpack_q ? (idx == {1'b0, len_q}) : (idx == {len_q, 1'b0});
  assign in_ready = busy & ~half;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      half     <= 1'b0;
      idx      <= '0;
      len_q    <= '0;
      unpack_q <= 1'b0;
      ascii_q  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        half     <= 1'b0;
        idx      <= '0;
        len_q    <= len_m1;
        unpack_q <= dir_unpack;
        ascii_q  <= ascii_mode;
      end
    end else if (half) begin
      half <= 1'b0;
      idx  <= idx + 1'b1;
    end else if (accept) begin
      if (abort || last) busy <= 1'b0;
      else if (unpack_q) half <= 1'b1;
      else               idx  <= idx + 1'b1;
    end
  end

  // R5
  half_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    half |=> !half);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(unpack_q) && $stable(ascii_q) && $stable(len_q)));

endmodule

// File: rtl/dzp_pack_lane.sv
module dzp_pack_lane
  import dzp_pkg::*;
(
  input  logic [BYTE_W-1:0] zbyte,
  input  nib_t              hold,
  input  logic              odd_pos,
  input  logic              last,
  input  logic              ascii,
  output logic              emit,
  output logic [BYTE_W-1:0] pbyte,
  output logic              bad
);

  nib_t digit;
  nib_t zone;

  always_comb begin
    digit = zbyte[NIB_W-1:0];
    zone  = zbyte[BYTE_W-1:NIB_W];
    bad   = !nib_is_digit(digit) || (last && !nib_is_sign(zone));
    emit  = last || odd_pos;
    if (last) pbyte = {digit, sign_pref(ascii, nib_is_minus(zone))};
    else      pbyte = {hold, digit};
  end

endmodule

// File: rtl/dzp_unpack_lane.sv
module dzp_unpack_lane
  import dzp_pkg::*;
(
  input  logic [BYTE_W-1:0] pbyte,
  input  logic              last,
  input  logic              ascii,
  output logic [BYTE_W-1:0] zbyte,
  output logic              bad
);

  logic [1:0] nib_ok;

  // nibble 0 is the low nibble: sign on the last byte, digit elsewhere
  for (genvar g = 0; g < 2; g++) begin : g_nib
    nib_t n;
    assign n = pbyte[g*NIB_W +: NIB_W];
    if (g == 0) begin : g_low
      assign nib_ok[g] = last ? nib_is_sign(n) : nib_is_digit(n);
    end else begin : g_high
      assign nib_ok[g] = nib_is_digit(n);
    end
  end

  always_comb begin
    bad = ~&nib_ok;
    if (last) zbyte = {sign_pref(ascii, nib_is_minus(pbyte[NIB_W-1:0])), pbyte[BYTE_W-1:NIB_W]};
    else      zbyte = {zone_plain(ascii), pbyte[BYTE_W-1:NIB_W]};
  end

endmodule

// File: rtl/dzp_conv.sv
module dzp_conv
  import dzp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_unpack,
  input  logic              ascii_mode,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              done,
  output logic              err
);

  localparam int IDX_W = LEN_W + 1;

  logic             busy, unpack_q, ascii_q, last, half, accept, bad;
  logic [IDX_W-1:0] idx;
  nib_t             hold_q;
  logic             p_emit, p_bad, u_bad;
  logic [BYTE_W-1:0] p_data, u_data;

  assign accept = in_valid & in_ready;
  assign bad    = unpack_q ? u_bad : p_bad;

  dzp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dir_unpack (dir_unpack),
    .ascii_mode (ascii_mode),
    .len_m1     (len_m1),
    .accept     (accept),
    .abort      (bad),
    .busy       (busy),
    .unpack_q   (unpack_q),
    .ascii_q    (ascii_q),
    .idx        (idx),
    .last       (last),
    .half       (half),
    .in_ready   (in_ready)
  );

  dzp_pack_lane u_pack (
    .zbyte   (in_data),
    .hold    (hold_q),
    .odd_pos (idx[0]),
    .last    (last),
    .ascii   (ascii_q),
    .emit    (p_emit),
    .pbyte   (p_data),
    .bad     (p_bad)
  );

  dzp_unpack_lane u_unpack (
    .pbyte (in_data),
    .last  (last),
    .ascii (ascii_q),
    .zbyte (u_data),
    .bad   (u_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      hold_q    <= '0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      if (accept) begin
        if (bad) begin
          done <= 1'b1;
          err  <= 1'b1;
        end else begin
          hold_q <= in_data[NIB_W-1:0];
          if (unpack_q) begin
            out_valid <= 1'b1;
            out_data  <= u_data;
            done      <= last;
          end else if (p_emit) begin
            out_valid <= 1'b1;
            out_data  <= p_data;
            done      <= last;
          end
        end
      end else if (half) begin
        out_valid <= 1'b1;
        out_data  <= {zone_plain(ascii_q), hold_q};
      end
    end
  end

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R8
  err_silent_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  zoned_digit_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unpack_q) |-> (out_data[NIB_W-1:0] <= nib_t'(9)));

  // R4
  pack_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done && out_valid && !unpack_q) |->
      (ascii_q ? (out_data[NIB_W-1:0] inside {4'hA, 4'hB})
               : (out_data[NIB_W-1:0] inside {4'hC, 4'hD})));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !half) |=> !out_valid);

endmodule

// File: tb/test_dzp_conv.sv
`timescale 1ns/1ps
module test_dzp_conv;

  logic       clk = 1'b0;
  logic       rst, start, dir_in, mode_in;
  logic [3:0] len_in;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready, out_valid, done, err;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;

  logic [7:0] stim[32];
  logic [7:0] exp_out[32];
  int         exp_n, exp_nin;
  bit         exp_err;

  logic [7:0] got[40];
  int         gcnt, dcnt, d_at;
  bit         d_err, d_val;

  always #2 clk = ~clk;

  dzp_conv #(.LEN_W(4)) i_dzp_conv (
    .clk(clk), .rst(rst), .start(start), .dir_unpack(dir_in),
    .ascii_mode(mode_in), .len_m1(len_in), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .done(done), .err(err)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      if (gcnt < 40) got[gcnt] = out_data;
      gcnt++;
    end
    if (done) begin
      dcnt++;
      d_err = err;
      d_val = out_valid;
      d_at  = gcnt;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] sgn(input bit a, input bit m);
    if (m) return a ? 4'hB : 4'hD;
    return a ? 4'hA : 4'hC;
  endfunction

  function automatic bit is_minus(input logic [3:0] n);
    return (n == 4'hB) || (n == 4'hD);
  endfunction

  task automatic model(input bit u, input bit a, input int L);
    logic [3:0] h = 4'h0;
    int nin = u ? L + 1 : 2 * L + 1;
    exp_n = 0; exp_err = 0; exp_nin = nin;
    for (int k = 0; k < nin; k++) begin
      logic [3:0] hi = stim[k][7:4];
      logic [3:0] lo = stim[k][3:0];
      bit lst = (k == nin - 1);
      if (!u) begin
        if (lo > 9 || (lst && hi < 10)) begin exp_err = 1; exp_nin = k + 1; break; end
        if (lst) exp_out[exp_n++] = {lo, sgn(a, is_minus(hi))};
        else if (k % 2 == 1) exp_out[exp_n++] = {h, lo};
        else h = lo;
      end else begin
        if (hi > 9 || (lst ? lo < 10 : lo > 9)) begin exp_err = 1; exp_nin = k + 1; break; end
        if (lst) exp_out[exp_n++] = {sgn(a, is_minus(lo)), hi};
        else begin
          exp_out[exp_n++] = {(a ? 4'h5 : 4'hF), hi};
          exp_out[exp_n++] = {(a ? 4'h5 : 4'hF), lo};
        end
      end
    end
  endtask

  // random valid field; rz gives random zones on inner zoned bytes
  task automatic fill(input bit u, input int L, input bit rz);
    int nin = u ? L + 1 : 2 * L + 1;
    for (int k = 0; k < nin; k++) begin
      logic [3:0] d1 = 4'($urandom % 10);
      logic [3:0] d2 = 4'($urandom % 10);
      logic [3:0] sc = 4'(10 + $urandom % 6);
      if (!u) stim[k] = {(k == nin - 1) ? sc : (rz ? 4'($urandom) : 4'hF), d1};
      else    stim[k] = {d1, (k == nin - 1) ? sc : d2};
    end
  endtask

  task automatic run_op(input bit u, input bit a, input int L, input bit glitch,
                        input string req);
    int  i = 0;
    bit  did = 0;
    model(u, a, L);
    gcnt = 0; dcnt = 0; d_err = 0; d_val = 0; d_at = 0;
    @(negedge clk);
    start = 1; dir_in = u; mode_in = a; len_in = 4'(L);
    @(negedge clk);
    start = 0;
    while (i < exp_nin) begin
      @(negedge clk);
      start = 0;
      if (glitch && i == 1 && !did) begin
        start = 1; dir_in = !u; mode_in = !a; len_in = ~len_in; did = 1;
      end
      if ($urandom % 4 == 0) in_valid = 0;
      else begin
        in_valid = 1; in_data = stim[i];
        #1;
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 0; start = 0;
    repeat (4) @(negedge clk);
    chk(dcnt == 1, req, "done pulses", dcnt, 1);
    chk(d_err == exp_err, exp_err ? "R8/R9" : req, "err at done", d_err, exp_err);
    chk(gcnt == exp_n, req, "result byte count", gcnt, exp_n);
    if (!exp_err) chk(d_val && d_at == exp_n, "R7", "done with final byte", d_at, exp_n);
    for (int j = 0; j < exp_n && j < gcnt; j++)
      chk(got[j] == exp_out[j], req, $sformatf("byte %0d", j), got[j], exp_out[j]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'd7331);
    rst = 1; start = 0; dir_in = 0; mode_in = 0; len_in = 0;
    in_data = 0; in_valid = 0; gcnt = 0; dcnt = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && !err && !in_ready, "R1", "outputs in reset",
        {out_valid, done, err, in_ready}, 0);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !done && !err && !in_ready, "R1", "outputs after reset",
        {out_valid, done, err, in_ready}, 0);

    // R12: valid while idle
    gcnt = 0; dcnt = 0;
    in_valid = 1; in_data = 8'hF3;
    repeat (5) begin
      @(negedge clk);
      chk(!in_ready, "R12", "ready while idle", in_ready, 0);
    end
    in_valid = 0;
    @(negedge clk);
    chk(gcnt == 0 && dcnt == 0, "R12", "output while idle", gcnt + dcnt, 0);

    // R3 R4: pack EBCDIC 12345 minus -> 12 34 5D
    stim[0] = 8'hF1; stim[1] = 8'hF2; stim[2] = 8'hF3; stim[3] = 8'hF4; stim[4] = 8'hD5;
    run_op(0, 0, 2, 0, "R3");
    // R4: ASCII pack, plus code E -> A
    stim[0] = 8'h57; stim[1] = 8'h58; stim[2] = 8'hE9;
    run_op(0, 1, 1, 0, "R4");
    // R4: ASCII pack, minus code D -> B
    stim[2] = 8'hD0;
    run_op(0, 1, 1, 0, "R4");
    // R5 R6: unpack EBCDIC 12 34 5C
    stim[0] = 8'h12; stim[1] = 8'h34; stim[2] = 8'h5C;
    run_op(1, 0, 2, 0, "R5");
    // R6: unpack ASCII minus code D -> zone B
    stim[0] = 8'h90; stim[1] = 8'h8D;
    run_op(1, 1, 1, 0, "R6");
    // R10: inner zones all zero
    for (int k = 0; k < 6; k++) stim[k] = {4'h0, 4'(k + 1)};
    stim[6] = 8'hC7;
    run_op(0, 0, 3, 0, "R10");
    // R11: shortest and longest
    stim[0] = 8'hB6; run_op(0, 0, 0, 0, "R11");
    stim[0] = 8'h4F; run_op(1, 1, 0, 0, "R11");
    fill(0, 15, 1); run_op(0, 1, 15, 0, "R11");
    fill(1, 15, 0); run_op(1, 0, 15, 0, "R11");
    // R8: bad digit in pack middle, in unpack high nibble, in first byte
    fill(0, 3, 1); stim[3][3:0] = 4'hC; run_op(0, 0, 3, 0, "R8");
    fill(1, 3, 0); stim[1][7:4] = 4'hA; run_op(1, 1, 3, 0, "R8");
    fill(1, 2, 0); stim[0][3:0] = 4'hF; run_op(1, 0, 2, 0, "R8");
    // R9: bad sign in both directions
    fill(0, 2, 1); stim[4][7:4] = 4'h9; run_op(0, 1, 2, 0, "R9");
    fill(1, 2, 0); stim[2][3:0] = 4'h3; run_op(1, 0, 2, 0, "R9");
    // R2: start while busy ignored
    fill(0, 4, 1); run_op(0, 0, 4, 1, "R2");
    fill(1, 4, 0); run_op(1, 1, 4, 1, "R2");

    // random mix
    for (int t = 0; t < 60; t++) begin
      bit u = bit'($urandom % 2);
      bit a = bit'($urandom % 2);
      int L = $urandom % 16;
      int nin = u ? L + 1 : 2 * L + 1;
      fill(u, L, 1);
      if ($urandom % 6 == 0) begin
        int k = $urandom % nin;
        if (!u) stim[k][3:0] = 4'(10 + $urandom % 6);
        else    stim[k][7:4] = 4'(10 + $urandom % 6);
      end
      run_op(u, a, L, 0, u ? "R5" : "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule